// File: doc/BRIEF.md
# Instruction stream classifier

This block observes the program counter of a processor, one sample for each retired instruction, and splits execution into streams. A stream is a run of instructions at consecutive word addresses with no taken branch between them. Whenever a stream ends, the block takes its start address and its length and looks the pair up in a hashed table. The lookup either returns the identifier already given to that stream, or assigns a fresh identifier and marks the stream as new.

Each result (identifier plus new flag) goes into a small output queue, which a slow consumer such as a serial transmitter drains under ready/valid flow control. Tracking and lookup never stall. When the queue is full, results are discarded and a saturating counter records how many were lost.

Top module: `stream_classifier`

## Requirements
- R1: After reset the output queue is empty (`sid_vld_o` low), the drop counter reads 0, every table entry is invalid and the first identifier handed out is 0.
- R2: A valid PC equal to the previous valid PC plus 4 extends the open stream. Any other valid PC closes the open stream and opens a new stream of length 1 at that PC. The first valid PC after reset opens a stream of length 1. Cycles with `pc_vld_i` low are ignored whatever `pc_i` holds.
- R3: A stream that grows to MAX_LEN instructions (default 32) closes at once, with that length. The next valid PC opens a new stream of length 1 even if it is sequential.
- R4: A closed stream is keyed by (start, length). Its table index is the XOR of the length (zero-extended) with 12-bit slices of the word address PC[31:2], taken from the least significant bit upward, the last slice zero-padded. The stored tag is PC[13:2].
- R5: On a miss (entry invalid, or its tag or length differs), the entry is overwritten with the key and the current value of the identifier counter. The result carries that identifier with the new flag high, and the counter then advances by one.
- R6: On a hit, the result carries the identifier stored in the entry with the new flag low, and the identifier counter is unchanged.
- R7: Two streams with the same length, the same PC[13:2] and the same table index are treated as the same stream (partial tag), so the second returns the first one's identifier as a hit.
- R8: Results leave the queue in the order the streams closed. `sid_vld_o` is high while the queue holds an entry, an entry is removed on a cycle with `sid_vld_o` and `sid_rdy_i` both high, and a held entry stays stable.
- R9: A result that arrives while the 8-entry queue is full is discarded and `ovf_cnt_o` increments, saturating at its all-ones value (255).
- R10: Streams closing on every consecutive cycle are all looked up and queued with no loss while the queue has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Program counter of the retired instruction |
| pc_vld_i | input | 1 | `pc_i` carries a retired instruction this cycle |
| sid_o | output | 16 | Stream identifier at the head of the queue |
| sid_vld_o | output | 1 | Queue head is valid |
| sid_new_o | output | 1 | Head stream was not in the table before |
| sid_rdy_i | input | 1 | Consumer takes the head entry |
| ovf_cnt_o | output | 8 | Saturating count of discarded results |

## Verification
The assertions assume that `pc_vld_i` is a clean, known strobe on every cycle after reset. They also assume that the consumer handshake follows ready/valid rules, so a head entry that is not taken must stay as it is. The bench drives PC and ready only at the falling edge, and it keeps `pc_i` at a garbage value whenever the strobe is low, so that an ignored sample can never pass for a real one. Under flow control the bench drops `sid_rdy_i` only once the pipeline has drained, so its model knows the queue occupancy without reading any design state.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int unsigned INSTR_BYTES = 4;
endpackage

// File: rtl/sc_tracker.sv
module sc_tracker
    import sc_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned MAX_LEN = 32,
    parameter int unsigned LEN_W   = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [PC_W-1:0]    pc_i,
    input  logic               pc_vld_i,
    output logic               done_o,
    output logic [PC_W-3:0]    start_o,
    output logic [LEN_W-1:0]   len_o
);
    localparam int unsigned WA_W = PC_W - 2;

    typedef struct packed {
        logic             active;
        logic [PC_W-1:0]  last;
        logic [WA_W-1:0]  start;
        logic [LEN_W-1:0] len;
        logic             done;
        logic [WA_W-1:0]  out_start;
        logic [LEN_W-1:0] out_len;
    } trk_t;

    trk_t             d, q;
    logic [PC_W-1:0]  seq_pc;
    logic [LEN_W-1:0] nlen;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        seq_pc = q.last + PC_W'(INSTR_BYTES);
        nlen   = q.len + LEN_W'(1);
        if (pc_vld_i) begin
            if (q.active && pc_i == seq_pc) begin
                d.last = pc_i;
                if (nlen == LEN_W'(MAX_LEN)) begin
                    d.done      = 1'b1;
                    d.out_start = q.start;
                    d.out_len   = nlen;
                    d.active    = 1'b0;
                end else begin
                    d.len = nlen;
                end
            end else begin
                if (q.active) begin
                    d.done      = 1'b1;
                    d.out_start = q.start;
                    d.out_len   = q.len;
                end
                d.active = 1'b1;
                d.last   = pc_i;
                d.start  = pc_i[PC_W-1:2];
                d.len    = LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign done_o  = q.done;
    assign start_o = q.out_start;
    assign len_o   = q.out_len;

    p_len_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |-> (q.out_len != '0 && q.out_len <= LEN_W'(MAX_LEN)));

    p_close_after_sample_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |-> $past(pc_vld_i));
endmodule

// File: rtl/sc_table.sv
module sc_table #(
    parameter int unsigned WA_W  = 30,
    parameter int unsigned LEN_W = 6,
    parameter int unsigned IDX_W = 12,
    parameter int unsigned TAG_W = 12,
    parameter int unsigned ID_W  = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             done_i,
    input  logic [WA_W-1:0]  wa_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             res_vld_o,
    output logic             res_new_o,
    output logic [ID_W-1:0]  res_id_o
);
    localparam int unsigned ENTRIES = 1 << IDX_W;
    localparam int unsigned NCHUNK  = (WA_W + IDX_W - 1) / IDX_W;
    localparam int unsigned PAD_W   = NCHUNK * IDX_W;

    typedef struct packed {
        logic            res_vld;
        logic            res_new;
        logic [ID_W-1:0] res_id;
        logic [ID_W-1:0] id_cnt;
    } tbl_t;

    tbl_t               d, q;
    logic [TAG_W-1:0]   tag_mem [ENTRIES];
    logic [LEN_W-1:0]   len_mem [ENTRIES];
    logic [ID_W-1:0]    id_mem  [ENTRIES];
    logic [ENTRIES-1:0] vld_q;

    logic [PAD_W-1:0]   wa_pad;
    logic [IDX_W-1:0]   idx;
    logic [TAG_W-1:0]   tag;
    logic               hit;
    logic               wr_en;

    always_comb begin
        wa_pad = PAD_W'(wa_i);
        idx    = IDX_W'(len_i);
        for (int c = 0; c < int'(NCHUNK); c++) begin
            idx = idx ^ wa_pad[c*IDX_W +: IDX_W];
        end
        tag   = wa_i[TAG_W-1:0];
        hit   = vld_q[idx] && tag_mem[idx] == tag && len_mem[idx] == len_i;
        wr_en = done_i && !hit;

        d         = q;
        d.res_vld = done_i;
        if (done_i) begin
            if (hit) begin
                d.res_new = 1'b0;
                d.res_id  = id_mem[idx];
            end else begin
                d.res_new = 1'b1;
                d.res_id  = q.id_cnt;
                d.id_cnt  = q.id_cnt + ID_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni)    vld_q      <= '0;
        else if (wr_en) vld_q[idx] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (wr_en) begin
            tag_mem[idx] <= tag;
            len_mem[idx] <= len_i;
            id_mem[idx]  <= q.id_cnt;
        end
    end

    assign res_vld_o = q.res_vld;
    assign res_new_o = q.res_new;
    assign res_id_o  = q.res_id;

    p_miss_advances_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.res_vld && q.res_new) |-> q.id_cnt == q.res_id + ID_W'(1));

    p_hit_keeps_counter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.res_vld && !q.res_new) |-> q.id_cnt == $past(q.id_cnt));
endmodule

// File: rtl/sc_outq.sv
module sc_outq #(
    parameter int unsigned W     = 17,
    parameter int unsigned DEPTH = 8,
    parameter int unsigned OVF_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             in_vld_i,
    input  logic [W-1:0]     in_data_i,
    output logic             out_vld_o,
    output logic [W-1:0]     out_data_o,
    input  logic             out_rdy_i,
    output logic [OVF_W-1:0] ovf_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rp;
        logic [PTR_W-1:0]        wp;
        logic [CNT_W-1:0]        cnt;
        logic [OVF_W-1:0]        ovf;
    } q_t;

    q_t   d, q;
    logic full, push, pop;

    always_comb begin
        full = q.cnt == CNT_W'(DEPTH);
        pop  = (q.cnt != '0) && out_rdy_i;
        push = in_vld_i && !full;
        d    = q;
        if (push) begin
            d.mem[q.wp] = in_data_i;
            d.wp        = q.wp + PTR_W'(1);
        end
        if (pop) d.rp = q.rp + PTR_W'(1);
        d.cnt = q.cnt + CNT_W'(push) - CNT_W'(pop);
        if (in_vld_i && full && q.ovf != '1) d.ovf = q.ovf + OVF_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign out_vld_o  = q.cnt != '0;
    assign out_data_o = q.mem[q.rp];
    assign ovf_o      = q.ovf;

    p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt <= CNT_W'(DEPTH));

    p_ovf_saturate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.ovf == '1) |=> (q.ovf == '1));

    p_drop_counted_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_vld_i && q.cnt == CNT_W'(DEPTH) && q.ovf != '1) |=> q.ovf == $past(q.ovf) + OVF_W'(1));
endmodule

// File: rtl/stream_classifier.sv
module stream_classifier #(
    parameter int unsigned PC_W       = 32,
    parameter int unsigned MAX_LEN    = 32,
    parameter int unsigned IDX_W      = 12,
    parameter int unsigned TAG_W      = 12,
    parameter int unsigned ID_W       = 16,
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned OVF_W      = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             pc_vld_i,
    output logic [ID_W-1:0]  sid_o,
    output logic             sid_vld_o,
    output logic             sid_new_o,
    input  logic             sid_rdy_i,
    output logic [OVF_W-1:0] ovf_cnt_o
);
    localparam int unsigned LEN_W = $clog2(MAX_LEN + 1);
    localparam int unsigned WA_W  = PC_W - 2;
    localparam int unsigned RES_W = ID_W + 1;

    logic             done;
    logic [WA_W-1:0]  start_wa;
    logic [LEN_W-1:0] len;
    logic             res_vld, res_new;
    logic [ID_W-1:0]  res_id;
    logic [RES_W-1:0] head;

    sc_tracker #(.PC_W(PC_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_trk (
        .clk_i(clk_i), .rst_ni(rst_ni), .pc_i(pc_i), .pc_vld_i(pc_vld_i),
        .done_o(done), .start_o(start_wa), .len_o(len));

    sc_table #(.WA_W(WA_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ID_W(ID_W)) u_tbl (
        .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .wa_i(start_wa), .len_i(len),
        .res_vld_o(res_vld), .res_new_o(res_new), .res_id_o(res_id));

    sc_outq #(.W(RES_W), .DEPTH(FIFO_DEPTH), .OVF_W(OVF_W)) u_q (
        .clk_i(clk_i), .rst_ni(rst_ni), .in_vld_i(res_vld), .in_data_i({res_new, res_id}),
        .out_vld_o(sid_vld_o), .out_data_o(head), .out_rdy_i(sid_rdy_i), .ovf_o(ovf_cnt_o));

    assign sid_new_o = head[RES_W-1];
    assign sid_o     = head[ID_W-1:0];

    p_hold_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sid_vld_o && !sid_rdy_i) |=> (sid_vld_o && $stable(sid_o) && $stable(sid_new_o)));
endmodule

// File: tb/stream_classifier_tb.sv
module stream_classifier_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc = '0;
    logic        pc_vld = 1'b0;
    logic        rdy = 1'b1;
    logic [15:0] sid;
    logic        sid_vld, sid_new;
    logic [7:0]  ovf;

    stream_classifier u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .pc_vld_i(pc_vld),
        .sid_o(sid), .sid_vld_o(sid_vld), .sid_new_o(sid_new),
        .sid_rdy_i(rdy), .ovf_cnt_o(ovf));

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0, fails = 0;
    string cur_req = "R1";
    logic [16:0] exp_q[$];

    // reference model built from the requirements
    bit          m_vld [4096];
    int          m_tag [4096];
    int          m_len [4096];
    int          m_id  [4096];
    int          next_id = 0;
    bit          act = 0;
    logic [31:0] cur_last, cur_start;
    int          cur_len;
    bit          hold = 0;
    int          held = 0;
    int          exp_ovf = 0;

    function automatic int fold(logic [31:0] p, int len);
        int wa = int'(p >> 2);
        return ((wa & 'hfff) ^ ((wa >> 12) & 'hfff) ^ ((wa >> 24) & 'hfff) ^ len) & 'hfff;
    endfunction

    function automatic void close_stream(logic [31:0] s, int len);
        int idx = fold(s, len);
        int tag = int'((s >> 2) & 32'hfff);
        logic [16:0] item;
        if (m_vld[idx] && m_tag[idx] == tag && m_len[idx] == len) begin
            item = {1'b0, 16'(m_id[idx])};
        end else begin
            m_vld[idx] = 1; m_tag[idx] = tag; m_len[idx] = len; m_id[idx] = next_id;
            item = {1'b1, 16'(next_id)};
            next_id++;
        end
        if (hold && held >= 8) begin
            if (exp_ovf < 255) exp_ovf++;
        end else begin
            exp_q.push_back(item);
            if (hold) held++;
        end
    endfunction

    function automatic void model_pc(logic [31:0] p);
        if (act && p == cur_last + 32'd4) begin
            cur_last = p;
            cur_len++;
            if (cur_len == 32) begin
                close_stream(cur_start, cur_len);
                act = 0;
            end
        end else begin
            if (act) close_stream(cur_start, cur_len);
            act = 1; cur_start = p; cur_last = p; cur_len = 1;
        end
    endfunction

    task automatic step(bit v, logic [31:0] p);
        @(negedge clk);
        pc_vld = v;
        pc = p;
        if (v) model_pc(p);
    endtask

    task automatic run(logic [31:0] s, int n);
        for (int i = 0; i < n; i++) step(1'b1, s + 32'(4 * i));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, 32'hDEAD_BEEF);
    endtask

    task automatic chk(bit ok, string req, int act_v, int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) idle(1);
        idle(4);
        chk(exp_q.size() == 0 && !sid_vld, cur_req, exp_q.size(), 0);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && sid_vld && rdy) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_req, int'({sid_new, sid}), -1);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    chk({sid_new, sid} == e, cur_req, int'({sid_new, sid}), int'(e));
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(3);
        cur_req = "R1";
        chk(!sid_vld, "R1", int'(sid_vld), 0);
        chk(ovf == 0, "R1", int'(ovf), 0);

        cur_req = "R5";              // first misses, ids 0 and 1
        run(32'h1000, 4);
        run(32'h2000, 3);
        cur_req = "R6";              // same stream again hits id 0
        run(32'h1000, 4);
        run(32'h3000, 2);
        drain();

        cur_req = "R2";              // gaps with garbage PC must not break the stream
        step(1'b1, 32'h1000); idle(2);
        step(1'b1, 32'h1004); idle(1);
        step(1'b1, 32'h1008);
        step(1'b1, 32'h100C);
        run(32'h4000, 1);
        drain();

        cur_req = "R3";              // cap at 32, sequential continuation restarts
        run(32'h8000, 40);
        run(32'h8000, 32);
        run(32'h6000, 2);
        drain();

        cur_req = "R4";              // same index, different tag evicts
        run(32'h5004, 4);
        run(32'h7000, 1);
        cur_req = "R5";
        run(32'h1000, 4);
        run(32'h7100, 1);
        drain();

        cur_req = "R7";              // alias: same tag, same index, upper bits differ
        run(32'h0400_5000, 4);
        run(32'h7200, 1);
        drain();

        cur_req = "R10";             // a stream closes every cycle
        for (int i = 0; i < 20; i++) step(1'b1, 32'h0010_0000 + 32'(i * 256));
        drain();

        cur_req = "R9";              // full queue drops
        @(negedge clk); rdy = 1'b0; hold = 1; held = 0;
        for (int i = 0; i < 12; i++) step(1'b1, 32'h9000_0000 + 32'(i * 256));
        idle(6);
        chk(ovf == 8'(exp_ovf), "R9", int'(ovf), exp_ovf);
        chk(sid_vld, "R9", int'(sid_vld), 1);
        cur_req = "R8";
        hold = 0;
        @(negedge clk); rdy = 1'b1;
        drain();

        cur_req = "R9";              // saturation
        @(negedge clk); rdy = 1'b0; hold = 1; held = 0;
        for (int i = 0; i < 300; i++) step(1'b1, 32'hA000_0000 + 32'(i * 256));
        idle(6);
        chk(ovf == 8'(exp_ovf), "R9", int'(ovf), exp_ovf);
        chk(exp_ovf == 255, "R9", exp_ovf, 255);
        hold = 0;
        @(negedge clk); rdy = 1'b1;
        drain();
        run(32'h0000_0400, 1);
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule